// File: doc/BRIEF.md
# Dynamic Priority Interrupt Arbiter

This block picks one winning interrupt line out of up to three banks of 32 lines. Each line has four inputs: a pending bit, a mask bit, a class-steering bit and a programmable priority value. Each line belongs to one of two classes. The normal class holds lines whose steering bit is 0. The fast class holds lines whose steering bit is 1. Each evaluation computes the winner for one class only. The caller chooses that class when it raises the start strobe.

The arbiter scans the banks one at a time, one bank per clock cycle. The best candidate seen so far is kept in an accumulator. When the last bank has been scanned, the result is written into the register for the class being evaluated, and a done pulse is raised. The two class registers are independent, so an interrupt handler can read either class at any time. The caller must keep the line inputs stable from start until done.

Top module: `prio_irq_arbiter`

## Requirements
- R1: A line is a candidate only when its pending bit is 1, its mask bit is 0 and its steering bit equals the evaluated class. `evalFiq`=1 selects the fast class (steering 1), and `evalFiq`=0 selects the normal class (steering 0).
- R2: Among the candidates, the one with the numerically smallest priority value wins, so 0 is the most urgent.
- R3: When several candidates share the best priority value, the candidate with the highest global line number wins. This holds within a bank and across banks.
- R4: The priority of line n is taken from `prioFlat[n*PRIO_W +: PRIO_W]`. The reported line number is 32 × bank + bit, where line n is bit n of the line vectors.
- R5: When no candidate exists, the class register holds line 0 and its valid flag is 0.
- R6: `evalDone` is a single-cycle pulse. It goes high exactly NUM_BANKS cycles after the rising clock edge that accepts `startEval`. The new result is visible in the same cycle as the pulse.
- R7: A start strobe that arrives while a scan is running is ignored. It neither restarts the scan nor changes its class.
- R8: The normal-class result (line and valid flag) changes only at the end of a normal-class evaluation. The fast-class result changes only at the end of a fast-class evaluation.
- R9: Reset clears both line outputs, both valid flags and `evalDone` to 0.
- R10: Priorities are compared over the full PRIO_W bits. With the default width of 6, a priority of 31 beats a priority of 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startEval | input | 1 | Launches an evaluation when the arbiter is idle |
| evalFiq | input | 1 | Class to evaluate: 1 = fast class, 0 = normal class |
| pendVec | input | 32*NUM_BANKS | Pending bit per line |
| maskVec | input | 32*NUM_BANKS | Mask bit per line (1 = masked) |
| fiqSteer | input | 32*NUM_BANKS | Class steering bit per line |
| prioFlat | input | 32*NUM_BANKS*PRIO_W | Priority field per line, packed with line 0 in the low bits |
| evalDone | output | 1 | One-cycle pulse when a result is committed |
| irqLine | output | 7 | Winning normal-class line |
| irqValid | output | 1 | A normal-class candidate existed |
| fiqLine | output | 7 | Winning fast-class line |
| fiqValid | output | 1 | A fast-class candidate existed |

## Verification
The directed patterns each isolate one rule:
- A single pending line in the first bank and another in the last bank separate the bank-offset arithmetic from the bit index.
- A masked line at top priority next to an unmasked lower-priority line shows that the mask is honoured.
- One line steered to each class shows that the class split works.
- Equal priorities placed in three banks, and also within one bank, tell the highest-line tie rule apart from first-found or lowest-line rules.
- Priorities of 31 and 32 reveal a comparison that is truncated to five bits.

An empty evaluation, run after a non-empty one, shows that the result returns to line 0. Long pseudo-random vectors with a narrow priority spread produce many ties and compound cases. These are checked against a reference that scans in descending order. Both class outputs are compared after every evaluation, which checks that the idle class is left untouched.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int BANK_LINES = 32;
  localparam int MAX_BANKS  = 3;
  localparam int BANK_IDX_W = 2;
  localparam int BIT_W      = 5;
  localparam int LINE_W     = BANK_IDX_W + BIT_W;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic                  clearAcc;
    logic                  accumulate;
    logic                  commit;
    logic                  forFiq;
    logic [BANK_IDX_W-1:0] bankSel;
  } arb_strobe_t;
endpackage

// File: rtl/arb_bank_pick.sv
module arb_bank_pick
  import arb_pkg::*;
#(
  parameter int PRIO_W = 6
) (
  input  logic [BANK_LINES-1:0]        candVec,
  input  logic [BANK_LINES*PRIO_W-1:0] prioVec,
  output logic                         found,
  output logic [PRIO_W-1:0]            bestPrio,
  output logic [BIT_W-1:0]             bestBit
);
  // Ascending scan with <= so a later (higher) bit wins a tie
  always_comb begin
    found    = 1'b0;
    bestPrio = '0;
    bestBit  = '0;
    for (int i = 0; i < BANK_LINES; i++) begin
      if (candVec[i] && (!found || prioVec[i*PRIO_W +: PRIO_W] <= bestPrio)) begin
        found    = 1'b1;
        bestPrio = prioVec[i*PRIO_W +: PRIO_W];
        bestBit  = BIT_W'(i);
      end
    end
  end

  // R1: the chosen bit must be a real candidate
  always_comb begin
    if (found) begin
      assert_pick_is_candidate_R1: assert (candVec[bestBit] == 1'b1);
    end
  end
endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
#(
  parameter int NUM_BANKS = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startEval,
  input  logic        evalFiq,
  output arb_strobe_t strobes,
  output logic        evalDone
);
  localparam logic [BANK_IDX_W-1:0] LAST_BANK = BANK_IDX_W'(NUM_BANKS - 1);

  if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS) begin : g_bad_banks
    $error("NUM_BANKS out of range");
  end

  logic                  busy;
  logic                  clsReg;
  logic [BANK_IDX_W-1:0] bankIdx;
  logic                  lastBank;

  assign lastBank = (bankIdx == LAST_BANK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      clsReg   <= 1'b0;
      bankIdx  <= '0;
      evalDone <= 1'b0;
    end else begin
      evalDone <= 1'b0;
      if (!busy) begin
        if (startEval) begin
          busy    <= 1'b1;
          bankIdx <= '0;
          clsReg  <= evalFiq;
        end
      end else if (lastBank) begin
        busy     <= 1'b0;
        evalDone <= 1'b1;
      end else begin
        bankIdx <= bankIdx + BANK_IDX_W'(1);
      end
    end
  end

  always_comb begin
    strobes.clearAcc   = !busy && startEval;
    strobes.accumulate = busy;
    strobes.commit     = busy && lastBank;
    strobes.forFiq     = clsReg;
    strobes.bankSel    = bankIdx;
  end

  // R6: the scan walks one bank per cycle
  assert_bank_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy && !lastBank |=> busy && (bankIdx == $past(bankIdx) + BANK_IDX_W'(1)));

  // R6: the last bank is followed by the done pulse
  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy && lastBank |=> evalDone && !busy);

  // R6: done lasts a single cycle
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    evalDone |=> !evalDone);

  // R7: a start during a scan leaves the class unchanged
  assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy && startEval |=> $stable(clsReg));
endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int PRIO_W    = 6
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  arb_strobe_t                           strobes,
  input  logic [BANK_LINES*NUM_BANKS-1:0]        pendVec,
  input  logic [BANK_LINES*NUM_BANKS-1:0]        maskVec,
  input  logic [BANK_LINES*NUM_BANKS-1:0]        fiqSteer,
  input  logic [BANK_LINES*NUM_BANKS*PRIO_W-1:0] prioFlat,
  output logic [LINE_W-1:0]                     irqLine,
  output logic                                  irqValid,
  output logic [LINE_W-1:0]                     fiqLine,
  output logic                                  fiqValid
);
  localparam int BANK_PRIO_W = BANK_LINES * PRIO_W;

  logic [BANK_LINES-1:0]  candByBank [NUM_BANKS];
  logic [BANK_PRIO_W-1:0] prioByBank [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign candByBank[b] = pendVec[b*BANK_LINES +: BANK_LINES]
                         & ~maskVec[b*BANK_LINES +: BANK_LINES]
                         & (strobes.forFiq ? fiqSteer[b*BANK_LINES +: BANK_LINES]
                                           : ~fiqSteer[b*BANK_LINES +: BANK_LINES]);
    assign prioByBank[b] = prioFlat[b*BANK_PRIO_W +: BANK_PRIO_W];
  end

  logic [BANK_LINES-1:0]  bankCand;
  logic [BANK_PRIO_W-1:0] bankPrioVec;

  always_comb begin
    bankCand    = '0;
    bankPrioVec = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (strobes.bankSel == BANK_IDX_W'(b)) begin
        bankCand    = candByBank[b];
        bankPrioVec = prioByBank[b];
      end
    end
  end

  logic              bankFound;
  logic [PRIO_W-1:0] bankPrio;
  logic [BIT_W-1:0]  bankBit;

  arb_bank_pick #(.PRIO_W(PRIO_W)) pick_i (
    .candVec (bankCand),
    .prioVec (bankPrioVec),
    .found   (bankFound),
    .bestPrio(bankPrio),
    .bestBit (bankBit)
  );

  logic              accFound;
  logic [PRIO_W-1:0] accPrio;
  logic [LINE_W-1:0] accLine;
  logic              mergeTake;
  logic              mergedFound;
  logic [PRIO_W-1:0] mergedPrio;
  logic [LINE_W-1:0] mergedLine;

  // Later banks hold higher line numbers, so <= gives them the tie
  assign mergeTake   = bankFound && (!accFound || bankPrio <= accPrio);
  assign mergedFound = accFound || bankFound;
  assign mergedPrio  = mergeTake ? bankPrio : accPrio;
  assign mergedLine  = mergeTake ? {strobes.bankSel, bankBit} : accLine;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accFound <= 1'b0;
      accPrio  <= '0;
      accLine  <= '0;
    end else if (strobes.clearAcc) begin
      accFound <= 1'b0;
      accPrio  <= '0;
      accLine  <= '0;
    end else if (strobes.accumulate) begin
      accFound <= mergedFound;
      accPrio  <= mergedPrio;
      accLine  <= mergedLine;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqLine  <= '0;
      irqValid <= 1'b0;
      fiqLine  <= '0;
      fiqValid <= 1'b0;
    end else if (strobes.commit) begin
      if (strobes.forFiq) begin
        fiqValid <= mergedFound;
        fiqLine  <= mergedFound ? mergedLine : '0;
      end else begin
        irqValid <= mergedFound;
        irqLine  <= mergedFound ? mergedLine : '0;
      end
    end
  end

  // R8: each class result moves only on its own commit
  assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.commit && !strobes.forFiq) |=> $stable(irqLine) && $stable(irqValid));

  assert_fiq_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.commit && strobes.forFiq) |=> $stable(fiqLine) && $stable(fiqValid));

  // R5: an empty result reads as line 0
  assert_empty_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!irqValid |-> irqLine == '0) and (!fiqValid |-> fiqLine == '0));

  // R4: the scanned bank index stays within the configured banks
  assert_bank_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.accumulate |-> int'(strobes.bankSel) < NUM_BANKS);
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int PRIO_W    = 6
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  startEval,
  input  logic                                  evalFiq,
  input  logic [32*NUM_BANKS-1:0]               pendVec,
  input  logic [32*NUM_BANKS-1:0]               maskVec,
  input  logic [32*NUM_BANKS-1:0]               fiqSteer,
  input  logic [32*NUM_BANKS*PRIO_W-1:0]        prioFlat,
  output logic                                  evalDone,
  output logic [6:0]                            irqLine,
  output logic                                  irqValid,
  output logic [6:0]                            fiqLine,
  output logic                                  fiqValid
);
  arb_strobe_t strobes;

  arb_ctrl #(.NUM_BANKS(NUM_BANKS)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .startEval(startEval),
    .evalFiq  (evalFiq),
    .strobes  (strobes),
    .evalDone (evalDone)
  );

  arb_datapath #(.NUM_BANKS(NUM_BANKS), .PRIO_W(PRIO_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .pendVec (pendVec),
    .maskVec (maskVec),
    .fiqSteer(fiqSteer),
    .prioFlat(prioFlat),
    .irqLine (irqLine),
    .irqValid(irqValid),
    .fiqLine (fiqLine),
    .fiqValid(fiqValid)
  );
endmodule

// File: tb/prio_irq_arbiter_tb_top.sv
`timescale 1ns/1ps
module prio_irq_arbiter_tb_top;
  localparam int NB = 3;
  localparam int PW = 6;
  localparam int NL = 32 * NB;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startEval = 1'b0;
  logic              evalFiq = 1'b0;
  logic [NL-1:0]     pendVec = '0;
  logic [NL-1:0]     maskVec = '0;
  logic [NL-1:0]     fiqSteer = '0;
  logic [NL*PW-1:0]  prioFlat = '0;
  logic              evalDone;
  logic [6:0]        irqLine;
  logic              irqValid;
  logic [6:0]        fiqLine;
  logic              fiqValid;

  int checks = 0;
  int errors = 0;
  int expIrqLine = 0;
  int expIrqValid = 0;
  int expFiqLine = 0;
  int expFiqValid = 0;
  logic [31:0] rngState = 32'h1234_abcd;

  always #2 clk = ~clk;

  prio_irq_arbiter #(.NUM_BANKS(NB), .PRIO_W(PW)) dut_i (
    .clk(clk), .rstN(rstN), .startEval(startEval), .evalFiq(evalFiq),
    .pendVec(pendVec), .maskVec(maskVec), .fiqSteer(fiqSteer), .prioFlat(prioFlat),
    .evalDone(evalDone), .irqLine(irqLine), .irqValid(irqValid),
    .fiqLine(fiqLine), .fiqValid(fiqValid)
  );

  task automatic checkEq(input string req, input string what, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic clearLines();
    pendVec = '0; maskVec = '0; fiqSteer = '0; prioFlat = '0;
  endtask

  task automatic setLine(input int n, input int prio, input bit fiq);
    pendVec[n] = 1'b1;
    fiqSteer[n] = fiq;
    prioFlat[n*PW +: PW] = PW'(prio);
  endtask

  function automatic int nextRand();
    rngState = rngState ^ (rngState << 13);
    rngState = rngState ^ (rngState >> 17);
    rngState = rngState ^ (rngState << 5);
    return int'(rngState);
  endfunction

  // Reference: scan from the top line downward, a strictly smaller priority replaces
  task automatic model(input bit fiq, output int line, output int valid);
    int bestP;
    line = 0; valid = 0; bestP = 0;
    for (int n = NL - 1; n >= 0; n--) begin
      if (pendVec[n] && !maskVec[n] && (fiqSteer[n] == fiq)) begin
        if (!valid || int'(prioFlat[n*PW +: PW]) < bestP) begin
          valid = 1; line = n; bestP = int'(prioFlat[n*PW +: PW]);
        end
      end
    end
  endtask

  // Runs one evaluation, checks the timing (R6) and both class outputs (R8)
  task automatic runEval(input bit fiq, input string req);
    int mLine, mValid;
    model(fiq, mLine, mValid);
    if (fiq) begin expFiqLine = mLine; expFiqValid = mValid; end
    else begin expIrqLine = mLine; expIrqValid = mValid; end
    evalFiq = fiq;
    startEval = 1'b1;
    for (int k = 0; k < NB; k++) begin
      @(negedge clk);
      startEval = 1'b0;
      checkEq("R6", "done early", int'(evalDone), 0);
    end
    @(negedge clk);
    checkEq("R6", "done on time", int'(evalDone), 1);
    checkEq(req, "irqLine", int'(irqLine), expIrqLine);
    checkEq(req, "irqValid", int'(irqValid), expIrqValid);
    checkEq(req, "fiqLine", int'(fiqLine), expFiqLine);
    checkEq(req, "fiqValid", int'(fiqValid), expFiqValid);
    @(negedge clk);
    checkEq("R6", "done single pulse", int'(evalDone), 0);
  endtask

  task automatic testReset();
    checkEq("R9", "reset irqLine", int'(irqLine), 0);
    checkEq("R9", "reset irqValid", int'(irqValid), 0);
    checkEq("R9", "reset fiqLine", int'(fiqLine), 0);
    checkEq("R9", "reset fiqValid", int'(fiqValid), 0);
    checkEq("R9", "reset done", int'(evalDone), 0);
  endtask

  task automatic testSingleLines();
    clearLines(); setLine(5, 9, 1'b0);
    runEval(1'b0, "R4 line5");
    clearLines(); setLine(70, 3, 1'b0);
    runEval(1'b0, "R4 line70");
  endtask

  task automatic testMask();
    clearLines(); setLine(10, 0, 1'b0); maskVec[10] = 1'b1; setLine(40, 9, 1'b0);
    runEval(1'b0, "R1 mask");
    checkEq("R1", "masked line skipped", int'(irqLine), 40);
  endtask

  task automatic testSteer();
    clearLines(); setLine(12, 0, 1'b1); setLine(20, 3, 1'b0);
    runEval(1'b0, "R1 steer irq");
    runEval(1'b1, "R1 steer fiq");
    checkEq("R8", "irq held over fiq eval", int'(irqLine), 20);
  endtask

  task automatic testPriority();
    clearLines(); setLine(3, 2, 1'b0); setLine(50, 7, 1'b0); setLine(90, 4, 1'b0);
    runEval(1'b0, "R2 lowest wins");
    checkEq("R2", "winner", int'(irqLine), 3);
  endtask

  task automatic testTies();
    clearLines(); setLine(1, 5, 1'b1); setLine(33, 5, 1'b1); setLine(65, 5, 1'b1);
    runEval(1'b1, "R3 cross bank tie");
    checkEq("R3", "cross bank winner", int'(fiqLine), 65);
    clearLines(); setLine(7, 0, 1'b1); setLine(9, 0, 1'b1); setLine(8, 1, 1'b1);
    runEval(1'b1, "R3 in bank tie");
    checkEq("R3", "in bank winner", int'(fiqLine), 9);
  endtask

  task automatic testWidePrio();
    clearLines(); setLine(80, 32, 1'b0); setLine(2, 31, 1'b0);
    runEval(1'b0, "R10 full width");
    checkEq("R10", "31 beats 32", int'(irqLine), 2);
  endtask

  task automatic testEmpty();
    clearLines(); setLine(30, 1, 1'b1);
    runEval(1'b1, "R5 before empty");
    clearLines(); setLine(30, 1, 1'b0);
    runEval(1'b1, "R5 empty fiq");
    checkEq("R5", "empty line", int'(fiqLine), 0);
    checkEq("R5", "empty valid", int'(fiqValid), 0);
  endtask

  task automatic testBusyStart();
    int mLine, mValid;
    clearLines(); setLine(44, 2, 1'b0); setLine(45, 2, 1'b1);
    model(1'b0, mLine, mValid);
    expIrqLine = mLine; expIrqValid = mValid;
    evalFiq = 1'b0; startEval = 1'b1;
    @(negedge clk);
    evalFiq = 1'b1;   // still strobing, now asking for the other class
    @(negedge clk);
    startEval = 1'b0;
    for (int k = 2; k < NB; k++) @(negedge clk);
    @(negedge clk);
    checkEq("R7", "done not restarted", int'(evalDone), 1);
    checkEq("R7", "class kept irqLine", int'(irqLine), expIrqLine);
    checkEq("R7", "fiq untouched", int'(fiqLine), expFiqLine);
    @(negedge clk);
    checkEq("R7", "no second done", int'(evalDone), 0);
  endtask

  task automatic testRandom();
    for (int t = 0; t < 30; t++) begin
      pendVec = {nextRand(), nextRand(), nextRand()};
      maskVec = {nextRand(), nextRand(), nextRand()};
      fiqSteer = {nextRand(), nextRand(), nextRand()};
      for (int n = 0; n < NL; n++) begin
        int r;
        r = nextRand();
        prioFlat[n*PW +: PW] = (t % 3 == 0) ? PW'(r) : PW'(r & 3);
      end
      runEval(t[0], "R2 R3 random");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSingleLines();
    testMask();
    testSteer();
    testPriority();
    testTies();
    testWidePrio();
    testEmpty();
    testBusyStart();
    testRandom();
    finishRun();
  end
endmodule